// File: doc/BRIEF.md
# DMA Descriptor Reuse Controller

This block sits in front of the descriptor fetch path of a USB device DMA engine. Each time an endpoint asks for a DMA transfer, the block decides whether the descriptor already held can be used again or whether a new one has to be loaded from memory. It keeps the last endpoint served and a live flag for that descriptor. A trigger from the same endpoint while the descriptor is still live gives a proceed pulse. Any other enabled trigger gives a fetch request for the triggering endpoint.

The block also keeps the running transfer count of the current descriptor. Each completed packet on an isochronous endpoint adds one. Each completed packet on a non-isochronous endpoint in normal mode adds its byte count. The count restarts at zero with every fetch. The two default control endpoints never take part in DMA. A trigger naming either of them is reported as an error.

Top module: `dma_desc_reuse_ctrl`

## Requirements
- R1: After reset, `fetch_req`, `proceed` and `ep_err` are 0, `present_count` is 0 and no descriptor is live, so the first enabled trigger produces a fetch.
- R2: A trigger with `trig_ep` equal to 0 or 1 gives a one-cycle `ep_err` pulse in the next cycle, with neither `fetch_req` nor `proceed`. The live descriptor and the count are left unchanged.
- R3: A trigger for an endpoint whose `dma_en` bit is 0 produces no output pulse and changes no state.
- R4: A trigger for the endpoint last served, while its descriptor is live, gives a one-cycle `proceed` pulse in the next cycle and no `fetch_req`.
- R5: Any other enabled trigger on endpoint 2 or above gives a one-cycle `fetch_req` pulse in the next cycle, with `fetch_ep` equal to the triggering endpoint. That endpoint becomes the live one.
- R6: A `desc_retired` pulse ends the live descriptor. When the pulse comes in the same cycle as a trigger, the trigger sees the descriptor as already retired and fetches.
- R7: A fetch sets `present_count` to 0 in the same cycle that `fetch_req` rises. This also holds when `pkt_done` comes in the triggering cycle.
- R8: On a live isochronous descriptor (captured from `trig_iso` at fetch), each `pkt_done` adds 1 to `present_count`, whatever `pkt_bytes` holds.
- R9: On a live non-isochronous descriptor with `desc_mode` = 2'b00 (normal), each `pkt_done` adds `pkt_bytes` to `present_count`.
- R10: On a live non-isochronous descriptor with `desc_mode` other than 2'b00, `pkt_done` leaves `present_count` unchanged.
- R11: `present_count` saturates at its all-ones value and never wraps.
- R12: `pkt_done` while no descriptor is live leaves `present_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | DMA trigger strobe |
| trig_ep | input | EP_W | Physical endpoint of the trigger |
| trig_iso | input | 1 | Triggering endpoint is isochronous |
| dma_en | input | EP_CNT | Per-endpoint DMA enable |
| desc_retired | input | 1 | Current descriptor has retired |
| desc_mode | input | 2 | Descriptor mode field, 2'b00 = normal |
| pkt_done | input | 1 | A packet transfer completed |
| pkt_bytes | input | BC_W | Bytes moved by the completed packet |
| fetch_req | output | 1 | Request to load a new descriptor |
| fetch_ep | output | EP_W | Endpoint whose descriptor is to be loaded |
| proceed | output | 1 | Current descriptor is reused |
| ep_err | output | 1 | Trigger named a control endpoint |
| present_count | output | CNT_W | Packets or bytes moved on this descriptor |

## Verification
Two collisions can happen in one cycle: a fetch with a packet completion, and a retirement with a trigger. The bench drives `pkt_done` with a byte count in the same cycle as a trigger for a new endpoint. It expects a count of zero, not the added value. It then pulses `desc_retired` in the same cycle as a trigger for the live endpoint and expects a fetch, not a proceed. A scoreboard model built from the requirements predicts every output cycle by cycle and judges both cases.

// File: rtl/dma_reuse_pkg.sv
package dma_reuse_pkg;

    typedef enum logic [1:0] {
        DEC_IDLE    = 2'd0,
        DEC_ERR     = 2'd1,
        DEC_PROCEED = 2'd2,
        DEC_FETCH   = 2'd3
    } decision_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam int         CTRL_EP_CNT = 2;

endpackage

// File: rtl/dr_decision.sv
module dr_decision
    import dma_reuse_pkg::*;
#(
    parameter int EP_CNT = 32,
    parameter int EP_W   = $clog2(EP_CNT)
) (
    input  logic              trig_valid,
    input  logic [EP_W-1:0]   trig_ep,
    input  logic [EP_CNT-1:0] dma_en,
    input  logic              live_eff,
    input  logic [EP_W-1:0]   last_ep,
    output decision_e         decision
);
    logic ep_is_ctrl;
    logic ep_enabled;

    always_comb begin
        ep_is_ctrl = (int'(trig_ep) < CTRL_EP_CNT);
        ep_enabled = 1'b0;
        if (int'(trig_ep) < EP_CNT) begin
            ep_enabled = dma_en[trig_ep];
        end
        decision = DEC_IDLE;
        if (trig_valid) begin
            if (ep_is_ctrl) begin
                decision = DEC_ERR;
            end else if (ep_enabled) begin
                if (live_eff && (trig_ep == last_ep)) begin
                    decision = DEC_PROCEED;
                end else begin
                    decision = DEC_FETCH;
                end
            end
        end
    end

endmodule

// File: rtl/dr_count_next.sv
module dr_count_next
    import dma_reuse_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BC_W  = 11
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic             clear,
    input  logic             pkt_done,
    input  logic             live,
    input  logic             iso,
    input  logic [1:0]       mode,
    input  logic [BC_W-1:0]  pkt_bytes,
    output logic [CNT_W-1:0] count_d
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] incr;
    logic [SUM_W-1:0] sum;

    always_comb begin
        incr = '0;
        if (iso) begin
            incr = SUM_W'(1);
        end else if (mode == MODE_NORMAL) begin
            incr = SUM_W'(pkt_bytes);
        end
        sum = {1'b0, count_q} + incr;

        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (pkt_done && live) begin
            if (sum[CNT_W]) begin
                count_d = '1;
            end else begin
                count_d = sum[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dma_desc_reuse_ctrl.sv
module dma_desc_reuse_ctrl
    import dma_reuse_pkg::*;
#(
    parameter int EP_CNT = 32,
    parameter int CNT_W  = 16,
    parameter int BC_W   = 11,
    parameter int EP_W   = $clog2(EP_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [EP_W-1:0]   trig_ep,
    input  logic              trig_iso,
    input  logic [EP_CNT-1:0] dma_en,
    input  logic              desc_retired,
    input  logic [1:0]        desc_mode,
    input  logic              pkt_done,
    input  logic [BC_W-1:0]   pkt_bytes,
    output logic              fetch_req,
    output logic [EP_W-1:0]   fetch_ep,
    output logic              proceed,
    output logic              ep_err,
    output logic [CNT_W-1:0]  present_count
);
    typedef struct packed {
        logic             live;
        logic [EP_W-1:0]  last_ep;
        logic             iso;
        logic [CNT_W-1:0] count;
        logic             fetch;
        logic             proc;
        logic             err;
    } state_t;

    state_t    st_d, st_q;
    decision_e dec;
    logic      live_eff;
    logic [CNT_W-1:0] count_nx;

    assign live_eff = st_q.live & ~desc_retired;

    dr_decision #(
        .EP_CNT (EP_CNT),
        .EP_W   (EP_W)
    ) u_decision (
        .trig_valid (trig_valid),
        .trig_ep    (trig_ep),
        .dma_en     (dma_en),
        .live_eff   (live_eff),
        .last_ep    (st_q.last_ep),
        .decision   (dec)
    );

    dr_count_next #(
        .CNT_W (CNT_W),
        .BC_W  (BC_W)
    ) u_count (
        .count_q   (st_q.count),
        .clear     (dec == DEC_FETCH),
        .pkt_done  (pkt_done),
        .live      (st_q.live),
        .iso       (st_q.iso),
        .mode      (desc_mode),
        .pkt_bytes (pkt_bytes),
        .count_d   (count_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.live  = live_eff;
        st_d.count = count_nx;
        st_d.fetch = 1'b0;
        st_d.proc  = 1'b0;
        st_d.err   = 1'b0;
        unique case (dec)
            DEC_ERR:     st_d.err  = 1'b1;
            DEC_PROCEED: st_d.proc = 1'b1;
            DEC_FETCH: begin
                st_d.fetch   = 1'b1;
                st_d.live    = 1'b1;
                st_d.last_ep = trig_ep;
                st_d.iso     = trig_iso;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_req     = st_q.fetch;
    assign fetch_ep      = st_q.last_ep;
    assign proceed       = st_q.proc;
    assign ep_err        = st_q.err;
    assign present_count = st_q.count;

    a_r5_fetch_excludes_proceed: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && proceed));

    a_r2_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        ep_err |-> (!fetch_req && !proceed));

    a_r2_ctrl_ep_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && int'(trig_ep) < CTRL_EP_CNT) |=> (ep_err && !fetch_req));

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && int'(trig_ep) >= CTRL_EP_CNT && int'(trig_ep) < EP_CNT && !dma_en[trig_ep])
        |=> (!fetch_req && !proceed && !ep_err));

    a_r4_proceed_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> st_q.live);

    a_r7_fetch_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (present_count == '0));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |-> (present_count >= $past(present_count)));

    a_r12_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.live && !trig_valid) |=> $stable(present_count));

endmodule

// File: tb/tb_dma_desc_reuse_ctrl.sv
module tb_dma_desc_reuse_ctrl;

    localparam int EP_CNT = 32;
    localparam int CNT_W  = 16;
    localparam int BC_W   = 11;
    localparam int EP_W   = $clog2(EP_CNT);
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_valid = 1'b0;
    logic [EP_W-1:0]   trig_ep = '0;
    logic              trig_iso = 1'b0;
    logic [EP_CNT-1:0] dma_en = '1;
    logic              desc_retired = 1'b0;
    logic [1:0]        desc_mode = 2'b00;
    logic              pkt_done = 1'b0;
    logic [BC_W-1:0]   pkt_bytes = '0;
    logic              fetch_req;
    logic [EP_W-1:0]   fetch_ep;
    logic              proceed;
    logic              ep_err;
    logic [CNT_W-1:0]  present_count;

    always #10 clk = ~clk;

    dma_desc_reuse_ctrl #(
        .EP_CNT (EP_CNT),
        .CNT_W  (CNT_W),
        .BC_W   (BC_W)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_valid    (trig_valid),
        .trig_ep       (trig_ep),
        .trig_iso      (trig_iso),
        .dma_en        (dma_en),
        .desc_retired  (desc_retired),
        .desc_mode     (desc_mode),
        .pkt_done      (pkt_done),
        .pkt_bytes     (pkt_bytes),
        .fetch_req     (fetch_req),
        .fetch_ep      (fetch_ep),
        .proceed       (proceed),
        .ep_err        (ep_err),
        .present_count (present_count)
    );

    typedef struct {
        bit    f;
        bit    p;
        bit    e;
        int    fep;
        int    cnt;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;

    bit   m_live = 0;
    int   m_ep = 0;
    bit   m_iso = 0;
    int   m_cnt = 0;

    task automatic step(bit tv, int ep, bit iso, bit dn, int by, bit rt,
                        bit [1:0] md, string tag);
        exp_t x;
        bit   live_eff;
        @(negedge clk);
        trig_valid   = tv;
        trig_ep      = EP_W'(ep);
        trig_iso     = iso;
        pkt_done     = dn;
        pkt_bytes    = BC_W'(by);
        desc_retired = rt;
        desc_mode    = md;
        x.f = 0; x.p = 0; x.e = 0; x.fep = 0; x.tag = tag;
        live_eff = m_live && !rt;
        if (tv) begin
            if (ep < 2) x.e = 1;
            else if (dma_en[ep]) begin
                if (live_eff && m_ep == ep) x.p = 1;
                else x.f = 1;
            end
        end
        if (x.f) begin
            m_cnt = 0;
        end else if (dn && m_live) begin
            if (m_iso) m_cnt = m_cnt + 1;
            else if (md == 2'b00) m_cnt = m_cnt + by;
            if (m_cnt > CMAX) m_cnt = CMAX;
        end
        m_live = x.f ? 1'b1 : live_eff;
        if (x.f) begin
            m_ep  = ep;
            m_iso = iso;
        end
        x.fep = ep;
        x.cnt = m_cnt;
        q.push_back(x);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 2'b00, tag);
    endtask

    initial begin : monitor
        exp_t x;
        bit   ok;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                x = q.pop_front();
                ok = (fetch_req == x.f) && (proceed == x.p) && (ep_err == x.e)
                     && (int'(present_count) == x.cnt)
                     && (!x.f || int'(fetch_ep) == x.fep);
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s: got f=%0b p=%0b e=%0b ep=%0d cnt=%0d exp f=%0b p=%0b e=%0b ep=%0d cnt=%0d",
                             x.tag, fetch_req, proceed, ep_err, fetch_ep, present_count,
                             x.f, x.p, x.e, x.fep, x.cnt);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        dma_en[5] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (fetch_req || proceed || ep_err || present_count != 0) begin
            bad++;
            $display("FAIL R1 reset: got f=%0b p=%0b e=%0b cnt=%0d expected all 0",
                     fetch_req, proceed, ep_err, present_count);
        end
        rst_n = 1'b1;
        step(1, 3, 0, 0, 0, 0, 2'b00, "R1 R5 first fetch");
        step(0, 0, 0, 1, 100, 0, 2'b00, "R9 byte add");
        step(1, 3, 0, 1, 50, 0, 2'b00, "R4 proceed with packet");
        step(1, 0, 0, 0, 0, 0, 2'b00, "R2 ep0 error");
        step(1, 1, 0, 0, 0, 0, 2'b00, "R2 ep1 error");
        step(1, 5, 0, 0, 0, 0, 2'b00, "R3 disabled ignored");
        step(1, 3, 0, 0, 0, 0, 2'b00, "R3 R2 state kept, proceed");
        step(0, 0, 0, 1, 30, 0, 2'b01, "R10 non-normal hold");
        step(0, 0, 0, 1, 30, 0, 2'b11, "R10 non-normal hold");
        step(1, 4, 0, 1, 20, 0, 2'b00, "R7 fetch beats packet");
        step(0, 0, 0, 1, 10, 0, 2'b00, "R9 byte add new desc");
        step(0, 0, 0, 0, 0, 1, 2'b00, "R6 retire");
        step(0, 0, 0, 1, 10, 0, 2'b00, "R12 packet while retired");
        step(1, 4, 0, 0, 0, 0, 2'b00, "R6 fetch after retire");
        step(1, 4, 0, 0, 0, 1, 2'b00, "R6 retire same cycle as trigger");
        step(1, 4, 0, 0, 0, 0, 2'b00, "R4 proceed after refetch");
        step(1, 7, 1, 0, 0, 0, 2'b00, "R5 iso fetch");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 500, 0, 2'b00, "R8 iso packet count");
        step(0, 0, 0, 1, 9, 0, 2'b10, "R8 iso ignores mode");
        step(1, 8, 0, 0, 0, 0, 2'b00, "R5 non-iso fetch");
        for (int i = 0; i < 40; i++) step(0, 0, 0, 1, 2047, 0, 2'b00, "R11 saturate");
        step(1, 9, 0, 0, 0, 0, 2'b00, "R7 fetch clears saturated");
        idle("idle tail");
        idle("idle tail");
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule